// File: doc/BRIEF.md
# Serial Memory Status and Write-Protection Controller

This block is the status-register and write-guard logic of a serial memory slave with a 256K x 8 array. It listens on a mode 0 serial link. A chip-select frame carries an 8-bit command, sent MSB first. The block handles four commands: set the write-enable latch, clear the write-enable latch, read the status byte, and write the status byte. It keeps the write-enable latch, a two-bit guard-size field, a lock bit and a busy flag. It also samples an active-low write-guard pin.

An accepted status write starts an internal programming interval, modelled by a countdown of `WR_CYCLES` clocks. During that interval the old lock and guard-size values stay in force, and the new values are committed when the countdown ends. When the lock bit is 1 and the guard pin is low, the status byte is frozen. A combinational port tells the array write path whether a given 18-bit address lies outside the guarded region.

The serial inputs are oversampled by the system clock through two-flop synchronisers. The system clock must therefore run well above the serial clock.

Top module: `spi_wp_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00, `miso_oe` is low and every address is reported writable.
- R2: Command 0x06 sets the write-enable latch and command 0x04 clears it. Either command takes effect only when chip select rises after exactly 8 serial clocks.
- R3: Command 0x05 returns the status byte on `miso`, MSB first, updated on falling serial clock edges. The first bit follows the 8th rising edge, and the byte repeats while chip select stays low. The byte layout is: bit 7 lock, bits 3:2 guard size, bit 1 write-enable latch, bit 0 busy, bits 6:4 zero. `miso_oe` is high only while status bits are being returned.
- R4: Command 0x01 followed by one data byte is accepted only when three conditions hold: the write-enable latch is 1, the frame ends after exactly 16 clocks, and the frozen state of R7 is not active. Data bits 6:4, 1 and 0 are discarded.
- R5: An accepted status write raises the busy bit for `WR_CYCLES` clocks. During that time the old lock and guard-size values remain visible and in force. The new values appear when busy falls.
- R6: The write-enable latch clears when busy falls. It also clears when a status-write frame of the wrong length arrives outside the frozen state.
- R7: When the lock bit is 1 and `wp_n` is low, a status write changes nothing at all, including the write-enable latch.
- R8: When `wp_n` is high, a lock bit of 1 does not block a status write.
- R9: While busy is 1, every command except status read is ignored.
- R10: `chk_ok` is 0 when the address lies in the guarded region. Guard size 00 guards nothing, 01 guards the top quarter of the array, 10 guards the top half and 11 guards the whole array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial link |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data in |
| wp_n | input | 1 | Active-low write-guard pin |
| chk_addr | input | ADDR_W | Array address to test |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for `miso`; low means high impedance |
| chk_ok | output | 1 | High when `chk_addr` may be written |

## Verification
The assertions assume the following of the inputs:
- Each serial clock half period lasts several system clocks.
- `mosi` is stable around rising serial edges.
- `wp_n` and chk_select do not change while a frame is in flight.

The stimulus follows these rules. Serial half periods are 8 clocks, and `wp_n` changes only between frames. After a status write the stimulus waits for the busy interval to end, or uses only short commands and reads inside it. The per-clock address comparison is masked for a few dozen clocks around the end of each programming interval, because the commit instant shifts with synchroniser latency.

// File: rtl/spi_wp_pkg.sv
package spi_wp_pkg;
  localparam logic [7:0] OP_SET_WEL = 8'h06;
  localparam logic [7:0] OP_CLR_WEL = 8'h04;
  localparam logic [7:0] OP_RD_STAT = 8'h05;
  localparam logic [7:0] OP_WR_STAT = 8'h01;

  typedef struct packed {
    logic       lock;
    logic [1:0] gsize;
    logic       wel;
    logic       busy;
  } wp_state_t;

  function automatic logic [7:0] pack_status(input wp_state_t s);
    return {s.lock, 3'b000, s.gsize, s.wel, s.busy};
  endfunction
endpackage

// File: rtl/spi_wp_rx.sv
module spi_wp_rx #(
  parameter int FRAME_BITS = 16,
  localparam int CNT_W = $clog2(FRAME_BITS + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             mosi,
  output logic             sel,
  output logic             sck_fall,
  output logic             op_stb,
  output logic             dat_stb,
  output logic [7:0]       rx_byte,
  output logic             frame_end,
  output logic [CNT_W-1:0] end_bits
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] OP_LAST = CNT_W'(7);
  localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(FRAME_BITS - 1);

  logic [2:0] cs_sr, sck_sr;
  logic [1:0] mo_sr;
  logic [6:0] sh;
  logic [CNT_W-1:0] cnt;
  logic sck_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_sr  <= 3'b111;
      sck_sr <= 3'b000;
      mo_sr  <= 2'b00;
    end else begin
      cs_sr  <= {cs_sr[1:0], cs_n};
      sck_sr <= {sck_sr[1:0], sclk};
      mo_sr  <= {mo_sr[0], mosi};
    end
  end

  assign sel       = ~cs_sr[1];
  assign sck_rise  = sel & sck_sr[1] & ~sck_sr[2];
  assign sck_fall  = sel & ~sck_sr[1] & sck_sr[2];
  assign frame_end = cs_sr[1] & ~cs_sr[2];
  assign end_bits  = cnt;

  always_ff @(posedge clk) begin
    if (rst || !sel) begin
      cnt <= '0;
      sh  <= '0;
    end else if (sck_rise) begin
      sh <= {sh[5:0], mo_sr[1]};
      if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_stb  <= 1'b0;
      dat_stb <= 1'b0;
      rx_byte <= '0;
    end else begin
      op_stb  <= sck_rise && (cnt == OP_LAST);
      dat_stb <= sck_rise && (cnt == DAT_LAST);
      if (sck_rise) rx_byte <= {sh, mo_sr[1]};
    end
  end

  AST_STROBES_APART: assert property (@(posedge clk) disable iff (rst)
    !(op_stb && dat_stb)); // R4
  AST_IDLE_COUNT: assert property (@(posedge clk) disable iff (rst)
    (cs_sr[2] && cs_sr[1]) |-> (cnt == '0)); // R2
endmodule

// File: rtl/spi_wp_ctl.sv
module spi_wp_ctl
  import spi_wp_pkg::*;
#(
  parameter int WR_CYCLES = 4000,
  parameter int FRAME_BITS = 16,
  localparam int CNT_W = $clog2(FRAME_BITS + 2),
  localparam int BUSY_W = $clog2(WR_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wp_n,
  input  logic             op_stb,
  input  logic             dat_stb,
  input  logic [7:0]       rx_byte,
  input  logic             frame_end,
  input  logic [CNT_W-1:0] end_bits,
  output wp_state_t        st
);
  localparam logic [BUSY_W-1:0] BUSY_LOAD = BUSY_W'(WR_CYCLES - 1);
  localparam logic [CNT_W-1:0]  LEN_CMD   = CNT_W'(8);
  localparam logic [CNT_W-1:0]  LEN_WR    = CNT_W'(FRAME_BITS);

  logic [1:0] wp_sr;
  logic [7:0] op_q, dat_q;
  logic       pend_lock;
  logic [1:0] pend_gsize;
  logic [BUSY_W-1:0] busy_cnt;
  logic frozen;

  assign frozen = ~wp_sr[1] & st.lock;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_sr      <= 2'b11;
      op_q       <= '0;
      dat_q      <= '0;
      pend_lock  <= 1'b0;
      pend_gsize <= '0;
      busy_cnt   <= '0;
      st         <= '0;
    end else begin
      wp_sr <= {wp_sr[0], wp_n};
      if (op_stb)  op_q  <= rx_byte;
      if (dat_stb) dat_q <= rx_byte;
      if (st.busy) begin
        if (busy_cnt == '0) begin
          st.lock  <= pend_lock;
          st.gsize <= pend_gsize;
          st.wel   <= 1'b0;
          st.busy  <= 1'b0;
        end else begin
          busy_cnt <= busy_cnt - 1'b1;
        end
      end else if (frame_end && end_bits >= LEN_CMD) begin
        case (op_q)
          OP_SET_WEL: if (end_bits == LEN_CMD) st.wel <= 1'b1;
          OP_CLR_WEL: if (end_bits == LEN_CMD) st.wel <= 1'b0;
          OP_WR_STAT: begin
            if (!frozen) begin
              if (end_bits == LEN_WR && st.wel) begin
                pend_lock  <= dat_q[7];
                pend_gsize <= dat_q[3:2];
                busy_cnt   <= BUSY_LOAD;
                st.busy    <= 1'b1;
              end else begin
                st.wel <= 1'b0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_OLD_VALUES_HELD: assert property (@(posedge clk) disable iff (rst)
    (st.busy && $past(st.busy)) |-> ($stable(st.gsize) && $stable(st.lock))); // R5
  AST_WEL_DROPS_AT_END: assert property (@(posedge clk) disable iff (rst)
    $fell(st.busy) |-> !st.wel); // R6
  AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (rst)
    $rose(st.busy) |-> $past(st.wel)); // R4
  AST_FROZEN_NO_START: assert property (@(posedge clk) disable iff (rst)
    $rose(st.busy) |-> !$past(frozen)); // R7
  AST_BUSY_KEEPS_WEL: assert property (@(posedge clk) disable iff (rst)
    (st.busy && $past(st.busy)) |-> $stable(st.wel)); // R9
endmodule

// File: rtl/spi_wp_tx.sv
module spi_wp_tx
  import spi_wp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sel,
  input  logic       sck_fall,
  input  logic       op_stb,
  input  logic [7:0] rx_byte,
  input  logic [7:0] status,
  output logic       miso,
  output logic       miso_oe
);
  logic       rd_act;
  logic [7:0] tx;
  logic [2:0] bit_i;

  always_ff @(posedge clk) begin
    if (rst || !sel) begin
      rd_act  <= 1'b0;
      miso_oe <= 1'b0;
      miso    <= 1'b0;
      tx      <= '0;
      bit_i   <= '0;
    end else if (op_stb && rx_byte == OP_RD_STAT) begin
      rd_act <= 1'b1;
      tx     <= status;
      bit_i  <= '0;
    end else if (rd_act && sck_fall) begin
      miso    <= tx[7];
      miso_oe <= 1'b1;
      if (bit_i == 3'd7) begin
        tx    <= status;
        bit_i <= '0;
      end else begin
        tx    <= {tx[6:0], 1'b0};
        bit_i <= bit_i + 1'b1;
      end
    end
  end

  AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
    miso_oe |-> rd_act); // R3
endmodule

// File: rtl/spi_wp_guard.sv
module spi_wp_guard #(
  parameter int ADDR_W = 18
) (
  input  logic [1:0]        gsize,
  input  logic [ADDR_W-1:0] addr,
  output logic              ok
);
  logic guarded;

  always_comb begin
    unique case (gsize)
      2'b00: guarded = 1'b0;
      2'b01: guarded = &addr[ADDR_W-1 -: 2];
      2'b10: guarded = addr[ADDR_W-1];
      default: guarded = 1'b1;
    endcase
    ok = ~guarded;
  end
endmodule

// File: rtl/spi_wp_ctrl.sv
module spi_wp_ctrl
  import spi_wp_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int WR_CYCLES = 4000,
  parameter int FRAME_BITS = 16,
  localparam int CNT_W = $clog2(FRAME_BITS + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              mosi,
  input  logic              wp_n,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              miso,
  output logic              miso_oe,
  output logic              chk_ok
);
  logic sel, sck_fall, op_stb, dat_stb, frame_end;
  logic [7:0] rx_byte;
  logic [CNT_W-1:0] end_bits;
  wp_state_t st;

  spi_wp_rx #(.FRAME_BITS(FRAME_BITS)) u_rx (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .sel(sel), .sck_fall(sck_fall), .op_stb(op_stb), .dat_stb(dat_stb),
    .rx_byte(rx_byte), .frame_end(frame_end), .end_bits(end_bits)
  );

  spi_wp_ctl #(.WR_CYCLES(WR_CYCLES), .FRAME_BITS(FRAME_BITS)) u_ctl (
    .clk(clk), .rst(rst), .wp_n(wp_n), .op_stb(op_stb), .dat_stb(dat_stb),
    .rx_byte(rx_byte), .frame_end(frame_end), .end_bits(end_bits), .st(st)
  );

  spi_wp_tx u_tx (
    .clk(clk), .rst(rst), .sel(sel), .sck_fall(sck_fall), .op_stb(op_stb),
    .rx_byte(rx_byte), .status(pack_status(st)), .miso(miso), .miso_oe(miso_oe)
  );

  spi_wp_guard #(.ADDR_W(ADDR_W)) u_guard (
    .gsize(st.gsize), .addr(chk_addr), .ok(chk_ok)
  );

  AST_TOP_ADDR_GUARDED: assert property (@(posedge clk) disable iff (rst)
    (st.gsize != 2'b00 && chk_addr == {ADDR_W{1'b1}}) |-> !chk_ok); // R10
  AST_BOTTOM_OPEN: assert property (@(posedge clk) disable iff (rst)
    (st.gsize != 2'b11 && chk_addr == '0) |-> chk_ok); // R10
endmodule

// File: tb/spi_wp_ctrl_test.sv
module spi_wp_ctrl_test;
  localparam int ADDR_W = 18;
  localparam int WRC = 600;

  logic clk = 1'b0, rst = 1'b1, cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0, wp_n = 1'b1;
  logic [ADDR_W-1:0] chk_addr = '0;
  logic miso, miso_oe, chk_ok;

  int nchk = 0, nfail = 0;
  bit valid = 0, done = 0;

  logic m_lock = 0, m_wel = 0, m_busy = 0, p_lock = 0;
  logic [1:0] m_gs = 0, p_gs = 0;
  int busy_left = 0;
  int aidx = 0;

  spi_wp_ctrl #(.ADDR_W(ADDR_W), .WR_CYCLES(WRC)) uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .wp_n(wp_n),
    .chk_addr(chk_addr), .miso(miso), .miso_oe(miso_oe), .chk_ok(chk_ok)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] m_stat();
    return {m_lock, 3'b000, m_gs, m_wel, m_busy};
  endfunction

  function automatic logic m_ok(input logic [ADDR_W-1:0] a);
    case (m_gs)
      2'b00: return 1'b1;
      2'b01: return a < 18'h30000;
      2'b10: return a < 18'h20000;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] corner(input int i);
    case (i)
      0: return 18'h00000;
      1: return 18'h1FFFF;
      2: return 18'h20000;
      3: return 18'h2FFFF;
      4: return 18'h30000;
      default: return 18'h3FFFF;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // programming interval of the model
  always @(posedge clk) begin
    if (busy_left > 0) begin
      busy_left <= busy_left - 1;
      if (busy_left == 1) begin
        m_lock <= p_lock; m_gs <= p_gs; m_wel <= 1'b0; m_busy <= 1'b0;
      end
    end
  end

  // per-clock comparison of the address check, R10
  always @(negedge clk) begin
    if (!rst) begin
      if (valid && !(busy_left > 0 && busy_left <= 30)) begin
        check(chk_ok === m_ok(chk_addr), "R10 chk_ok", chk_ok, m_ok(chk_addr));
      end
      aidx <= (aidx + 1) % 6;
      chk_addr <= corner((aidx + 1) % 6);
    end
  end

  task automatic frame(input logic [23:0] v, input int nb, output logic [7:0] rd,
                       output bit oe_all, output bit oe_any);
    valid = 0; rd = '0; oe_all = 1; oe_any = 0;
    cs_n = 1'b0; idle(8);
    for (int i = 0; i < nb; i++) begin
      sclk = 1'b0; mosi = v[23-i]; idle(8);
      sclk = 1'b1; idle(4);
      if (i >= 8 && i < 16) begin
        rd = {rd[6:0], miso};
        if (miso_oe !== 1'b1) oe_all = 0;
      end
      if (miso_oe === 1'b1) oe_any = 1;
      idle(4);
    end
    sclk = 1'b0; idle(8);
    cs_n = 1'b1; idle(16);
  endtask

  task automatic cmd(input logic [7:0] op, input int nb);
    logic [7:0] rd; bit a, b;
    frame({op, 16'h0}, nb, rd, a, b);
    if (!m_busy && nb == 8) begin
      if (op == 8'h06) m_wel = 1'b1;
      if (op == 8'h04) m_wel = 1'b0;
    end
    valid = 1;
  endtask

  task automatic wrstat(input logic [7:0] d, input int nb);
    logic [7:0] rd; bit a, b;
    frame({8'h01, d, 8'h00}, nb, rd, a, b);
    check(!b, "R3 output idle during status write", b, 0);
    if (!m_busy && !(!wp_n && m_lock)) begin
      if (nb == 16 && m_wel) begin
        p_lock = d[7]; p_gs = d[3:2]; m_busy = 1'b1; busy_left = WRC;
      end else m_wel = 1'b0;
    end
    valid = 1;
  endtask

  task automatic rdstat(input string tag, input logic [7:0] lit, input bit use_lit);
    logic [7:0] rd; bit a, b;
    logic [7:0] exp;
    frame({8'h05, 16'h0}, 16, rd, a, b);
    exp = use_lit ? lit : m_stat();
    check(rd === exp, tag, rd, exp);
    check(a, "R3 miso_oe during status bits", a, 1);
    check(miso_oe === 1'b0, "R3 miso_oe after frame", miso_oe, 0);
    valid = 1;
  endtask

  task automatic wait_idle();
    while (busy_left > 0) @(negedge clk);
    idle(8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    idle(5);
    rst = 1'b0;
    idle(4);
    check(miso_oe === 1'b0, "R1 miso_oe after reset", miso_oe, 0);
    valid = 1;
    idle(20);
    rdstat("R1 reset status", 8'h00, 1);

    cmd(8'h06, 8);
    rdstat("R2 set latch", 8'h02, 1);
    cmd(8'h04, 8);
    rdstat("R2 clear latch", 8'h00, 1);
    cmd(8'h06, 9);
    rdstat("R2 nine-clock frame ignored", 8'h00, 1);

    wrstat(8'h0C, 16);
    rdstat("R4 write without latch refused", 8'h00, 1);

    cmd(8'h06, 8);
    wrstat(8'h04, 16);
    cmd(8'h04, 8);
    rdstat("R9 R5 busy keeps old values and latch", 8'h03, 1);
    wait_idle();
    rdstat("R5 R6 committed, latch cleared", 8'h04, 1);

    cmd(8'h06, 8);
    wrstat(8'h08, 17);
    rdstat("R6 R4 wrong length discarded", 8'h04, 1);

    cmd(8'h06, 8);
    wrstat(8'h88, 16);
    wait_idle();
    rdstat("R5 lock and half guard", 8'h88, 1);

    wp_n = 1'b0; idle(8);
    cmd(8'h06, 8);
    wrstat(8'h00, 16);
    rdstat("R7 frozen, write ignored, latch kept", 8'h8A, 1);

    wp_n = 1'b1; idle(8);
    wrstat(8'hFC, 16);
    wait_idle();
    rdstat("R8 R4 pin high allows write, unused bits zero", 8'h8C, 1);

    cmd(8'h06, 8);
    wrstat(8'h00, 16);
    wait_idle();
    rdstat("R8 cleared", 8'h00, 1);
    rdstat("R3 model agreement", 8'h00, 0);

    idle(20);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule